// File: doc/BRIEF.md
# Byte-Sliced Register File

This block is a small multi-ported register file whose words are reached one byte lane at a time. It holds sixteen 32-bit words, and each word is cut into four 8-bit slices. A single slice selector, shared by every port in a cycle, picks the lane. Two read ports and one write port work in parallel. Each read port returns an 8-bit value from the word named by its own address. The write port stores an 8-bit value into the chosen lane of one word on the rising clock edge.

Word 0 is a hard zero. It reads as zero on every port from power-on, before any reset, and every write aimed at it is dropped. Reads are purely combinational. There is no path that forwards write data to a read, so a read of the word being written in the same cycle still shows the old contents. A synchronous, active-high reset clears the whole array and wins over a write in the same cycle. A debug bus carries the full array so that lanes and words nobody selected can be observed.

Top module: `rf_slice_bank`

## Requirements
- R1: One clock edge taken with `rst` high leaves every bit of `dbg_words` at zero.
- R2: An edge with `wr_en` high, `rst` low and `wr_addr` nonzero loads `wr_data` into lane `slice_sel` of word `wr_addr`. Every other lane of that word, and every other word, keeps its value.
- R3: An edge with `wr_en` low and `rst` low leaves the whole array unchanged.
- R4: A write with `wr_addr` equal to 0 is dropped, so the array, including word 0, is unchanged after that edge.
- R5: For a nonzero address, read port p returns lane `slice_sel` of word `rd_addr[p]` in the same cycle, with no clock edge in between.
- R6: A read port whose address is 0 returns 0 at all times, including before the first reset.
- R7: While a write to word w is pending, a read of w in that cycle returns the value held before the edge. After the edge, the read returns the new value.
- R8: When `rst` and `wr_en` are both high on an edge, the reset wins and the array ends all zero.
- R9: Lane k of a word is bits [8k+7:8k] of that word, so lane 0 is the least significant byte. Word w sits at bits [32w+31:32w] of `dbg_words`, and port p uses bits [4p+3:4p] of `rd_addr` and [8p+7:8p] of `rd_data`.
- R10: The one `slice_sel` value chooses the lane for both read ports and for the write port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset take effect on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the array |
| slice_sel | input | 2 | Lane selector shared by all ports |
| rd_addr | input | 8 | Two packed 4-bit read addresses, port 0 in the low bits |
| rd_data | output | 16 | Two packed 8-bit read results, port 0 in the low bits |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Word written on the edge |
| wr_data | input | 8 | Lane value written on the edge |
| dbg_words | output | 512 | Whole array, word 0 in the low bits |

## Verification
The checker properties expect clean, fully known values on `rst`, `wr_en`, the addresses and `slice_sel` at every rising edge. They also expect `rst` to be held high on the first edge. That edge starts the checker's memory of the previous cycle, and before it the array contents are undefined. The bench meets both conditions: it drives every input from time zero, changes inputs only on falling edges, and keeps reset asserted through the first two rising edges. It reads port 0 at address 0 before the first edge. No other check depends on array contents that were never written.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int DEF_WORDS    = 16;
  localparam int DEF_WORD_W   = 32;
  localparam int DEF_SLICE_W  = 8;
  localparam int DEF_RD_PORTS = 2;

  // number of lanes a word splits into
  function automatic int lanes(input int word_w, input int slice_w);
    return word_w / slice_w;
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write request into one enable per (word, lane), words 1..WORDS-1.
module rf_wr_decode #(
  parameter int WORDS  = rf_pkg::DEF_WORDS,
  parameter int SLICES = 4,
  parameter int ADDR_W = $clog2(WORDS),
  parameter int SEL_W  = $clog2(SLICES)
) (
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [SEL_W-1:0]              slice_sel,
  output logic [(WORDS-1)*SLICES-1:0]   lane_we
);

  for (genvar w = 1; w < WORDS; w++) begin : g_word
    for (genvar s = 0; s < SLICES; s++) begin : g_lane
      assign lane_we[(w-1)*SLICES + s] =
        wr_en && (wr_addr == ADDR_W'(w)) && (slice_sel == SEL_W'(s));
    end
  end

endmodule

// File: rtl/rf_word.sv
// One storage word, each lane written on its own enable; reset wins.
module rf_word #(
  parameter int WORD_W  = rf_pkg::DEF_WORD_W,
  parameter int SLICE_W = rf_pkg::DEF_SLICE_W,
  parameter int SLICES  = rf_pkg::lanes(WORD_W, SLICE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SLICES-1:0]  lane_we,
  input  logic [SLICE_W-1:0] wr_data,
  output logic [WORD_W-1:0]  word_q
);

  logic [SLICES-1:0][SLICE_W-1:0] lanes_q;

  for (genvar s = 0; s < SLICES; s++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lanes_q[s] <= '0;
      end else if (lane_we[s]) begin
        lanes_q[s] <= wr_data;
      end
    end
  end

  assign word_q = lanes_q;

endmodule

// File: rtl/rf_rd_port.sv
// Zero-latency read of one lane from one word; address 0 forced to zero.
module rf_rd_port #(
  parameter int WORDS   = rf_pkg::DEF_WORDS,
  parameter int WORD_W  = rf_pkg::DEF_WORD_W,
  parameter int SLICE_W = rf_pkg::DEF_SLICE_W,
  parameter int SLICES  = rf_pkg::lanes(WORD_W, SLICE_W),
  parameter int ADDR_W  = $clog2(WORDS),
  parameter int SEL_W   = $clog2(SLICES)
) (
  input  logic [WORDS-1:0][WORD_W-1:0] words,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [SEL_W-1:0]             slice_sel,
  output logic [SLICE_W-1:0]           rd_data
);

  logic [SLICES-1:0][SLICE_W-1:0] picked;

  always_comb begin
    picked = words[rd_addr];
    if (rd_addr == '0) begin
      rd_data = '0;
    end else begin
      rd_data = picked[slice_sel];
    end
  end

endmodule

// File: rtl/rf_slice_bank.sv
module rf_slice_bank #(
  parameter int WORDS     = rf_pkg::DEF_WORDS,
  parameter int WORD_W    = rf_pkg::DEF_WORD_W,
  parameter int SLICE_W   = rf_pkg::DEF_SLICE_W,
  parameter int RD_PORTS  = rf_pkg::DEF_RD_PORTS,
  localparam int SLICES   = rf_pkg::lanes(WORD_W, SLICE_W),
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int SEL_W    = $clog2(SLICES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_W-1:0]              slice_sel,
  input  logic [RD_PORTS*ADDR_W-1:0]    rd_addr,
  output logic [RD_PORTS*SLICE_W-1:0]   rd_data,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [SLICE_W-1:0]            wr_data,
  output logic [WORDS*WORD_W-1:0]       dbg_words
);

  logic [(WORDS-1)*SLICES-1:0]  lane_we;
  logic [WORDS-1:0][WORD_W-1:0] words;

  rf_wr_decode #(
    .WORDS  (WORDS),
    .SLICES (SLICES),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_dec (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .slice_sel (slice_sel),
    .lane_we   (lane_we)
  );

  // word 0 is a constant, no storage behind it
  assign words[0] = '0;

  for (genvar w = 1; w < WORDS; w++) begin : g_store
    rf_word #(
      .WORD_W  (WORD_W),
      .SLICE_W (SLICE_W),
      .SLICES  (SLICES)
    ) u_word (
      .clk     (clk),
      .rst     (rst),
      .lane_we (lane_we[(w-1)*SLICES +: SLICES]),
      .wr_data (wr_data),
      .word_q  (words[w])
    );
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    rf_rd_port #(
      .WORDS   (WORDS),
      .WORD_W  (WORD_W),
      .SLICE_W (SLICE_W),
      .SLICES  (SLICES),
      .ADDR_W  (ADDR_W),
      .SEL_W   (SEL_W)
    ) u_rd (
      .words     (words),
      .rd_addr   (rd_addr[p*ADDR_W +: ADDR_W]),
      .slice_sel (slice_sel),
      .rd_data   (rd_data[p*SLICE_W +: SLICE_W])
    );
  end

  assign dbg_words = words;

endmodule

// File: rtl/rf_slice_bank_chk.sv
module rf_slice_bank_chk #(
  parameter int WORDS     = rf_pkg::DEF_WORDS,
  parameter int WORD_W    = rf_pkg::DEF_WORD_W,
  parameter int SLICE_W   = rf_pkg::DEF_SLICE_W,
  parameter int RD_PORTS  = rf_pkg::DEF_RD_PORTS,
  localparam int SLICES   = rf_pkg::lanes(WORD_W, SLICE_W),
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int SEL_W    = $clog2(SLICES)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [SEL_W-1:0]            slice_sel,
  input logic [RD_PORTS*ADDR_W-1:0]  rd_addr,
  input logic [RD_PORTS*SLICE_W-1:0] rd_data,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [SLICE_W-1:0]          wr_data,
  input logic [WORDS*WORD_W-1:0]     dbg_words
);

  logic [WORDS-1:0][SLICES-1:0][SLICE_W-1:0] cur, prv_arr, expect_arr;
  logic               prv_ok, prv_en;
  logic [ADDR_W-1:0]  prv_addr;
  logic [SEL_W-1:0]   prv_sel;
  logic [SLICE_W-1:0] prv_data;

  assign cur = dbg_words;

  always_ff @(posedge clk) begin
    prv_ok   <= !rst;
    prv_en   <= wr_en;
    prv_addr <= wr_addr;
    prv_sel  <= slice_sel;
    prv_data <= wr_data;
    prv_arr  <= dbg_words;
  end

  always_comb begin
    expect_arr = prv_arr;
    expect_arr[prv_addr][prv_sel] = prv_data;
  end

  p_clear_r1: assert property (@(posedge clk) rst |=> (dbg_words == '0));

  p_rst_wins_r8: assert property (@(posedge clk) (rst && wr_en) |=> (dbg_words == '0));

  p_lane_write_r2: assert property (@(posedge clk) disable iff (rst)
    (prv_ok && prv_en && (prv_addr != '0)) |-> (cur == expect_arr));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (prv_ok && !prv_en) |-> (cur == prv_arr));

  p_zero_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (prv_ok && prv_en && (prv_addr == '0)) |-> (cur == prv_arr));

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    p_read_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_addr[p*ADDR_W +: ADDR_W] != '0) |->
      (rd_data[p*SLICE_W +: SLICE_W] == cur[rd_addr[p*ADDR_W +: ADDR_W]][slice_sel]));

    p_zero_read_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_addr[p*ADDR_W +: ADDR_W] == '0) |-> (rd_data[p*SLICE_W +: SLICE_W] == '0));

    p_no_bypass_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr != '0) && (rd_addr[p*ADDR_W +: ADDR_W] == wr_addr)) |->
      (rd_data[p*SLICE_W +: SLICE_W] == cur[wr_addr][slice_sel]));
  end

endmodule

bind rf_slice_bank rf_slice_bank_chk #(
  .WORDS    (WORDS),
  .WORD_W   (WORD_W),
  .SLICE_W  (SLICE_W),
  .RD_PORTS (RD_PORTS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slice_sel (slice_sel),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .dbg_words (dbg_words)
);

// File: tb/sim_rf_slice_bank.sv
module sim_rf_slice_bank;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   slice_sel;
  logic [7:0]   rd_addr;
  logic [15:0]  rd_data;
  logic         wr_en;
  logic [3:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [511:0] dbg_words;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] mdl [16];

  rf_slice_bank u0 (
    .clk(clk), .rst(rst), .slice_sel(slice_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_words(dbg_words)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_of(input int a, input int s);
    if (a == 0) return 8'h00;
    return 8'((mdl[a] >> (8*s)) & 32'hFF);
  endfunction

  task automatic check_array(input string tag);
    for (int w = 0; w < 16; w++) check(tag, dbg_words[w*32 +: 32], mdl[w]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    slice_sel = '0; rd_addr = '0;
    for (int w = 0; w < 16; w++) mdl[w] = '0;
    #2;
    // R6: address 0 reads zero before any reset edge
    check("R6 pre-reset port0", {24'h0, rd_data[7:0]}, 32'h0);
    check("R6 pre-reset port1", {24'h0, rd_data[15:8]}, 32'h0);
    @(negedge clk); @(negedge clk);
    check_array("R1 reset clears");
    rst = 1'b0;

    // fill every word and lane; read the same word in the write cycle
    for (int w = 0; w < 16; w++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(w); slice_sel = 2'(s);
        wr_data = 8'(w*37 + s*11 + 1);
        rd_addr = {4'(w), 4'(w)};
        #1;
        check("R7 old value in write cycle", {24'h0, rd_data[7:0]}, {24'h0, lane_of(w, s)});
        if (w != 0) mdl[w] = (mdl[w] & ~(32'hFF << (8*s))) | (32'(wr_data) << (8*s));
        @(negedge clk);
        wr_en = 1'b0;
        if (w == 0) check_array("R4 word 0 write dropped");
        else check_array("R2 single lane written");
        #1;
        check("R7 new value after edge", {24'h0, rd_data[15:8]}, {24'h0, lane_of(w, s)});
      end
    end

    // exhaustive read sweep, both ports share the lane selector
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 16; a++) begin
        @(negedge clk);
        slice_sel = 2'(s); rd_addr = {4'(15 - a), 4'(a)};
        #1;
        check((a == 0) ? "R6 port0 zero" : "R5 R10 port0",
              {24'h0, rd_data[7:0]}, {24'h0, lane_of(a, s)});
        check((a == 15) ? "R6 port1 zero" : "R5 R10 port1",
              {24'h0, rd_data[15:8]}, {24'h0, lane_of(15 - a, s)});
      end
    end

    // disabled writes change nothing
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'd5; slice_sel = 2'(k); wr_data = 8'hFF;
    end
    @(negedge clk);
    check_array("R3 enable low holds");

    // lane position: word 9 lane 2 is bits 23:16
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd9; slice_sel = 2'd2; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 lane 2 bits", {24'h0, dbg_words[9*32+16 +: 8]}, 32'hC3);
    check("R9 other lanes", {dbg_words[9*32+24 +: 8], 8'h00, dbg_words[9*32 +: 16]},
          mdl[9] & 32'hFF00_FFFF);
    mdl[9] = (mdl[9] & 32'hFF00_FFFF) | 32'h00C3_0000;
    check_array("R2 lane overwrite");

    // write to address 0 with read at 0
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; slice_sel = 2'd3; wr_data = 8'h77; rd_addr = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check_array("R4 address 0 ignored");
    check("R6 read 0 after write", {16'h0, rd_data}, 32'h0);

    // reset and write on the same edge
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; slice_sel = 2'd1; wr_data = 8'hAA;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int w = 0; w < 16; w++) mdl[w] = '0;
    check_array("R8 reset beats write");
    check_array("R1 reset clears again");

    finish_run();
  end

endmodule